// File: doc/BRIEF.md
# Configuration Clock Burst Counter

This block sends a set number of configuration clock pulses to a device that is being configured, and then raises a completion flag that stays set. Software writes the pulse count to a count register, and that write starts the burst. Each pulse lasts two system clock cycles: the output is high for one cycle and low for the next. While the burst runs, a busy indication is set. When the last pulse has been sent, a done flag is set and stays set until software clears it by writing one to its bit in the status register.

The bus side is a simple register port. A write takes effect at the clock edge where `bus_wr` is high. Read data comes back registered, in the cycle after `bus_rd` is asserted. The count register is at byte offset 0x8 and the status register is at byte offset 0xC. A typical use is the closing step of a configuration sequence, which works as follows:

1. Software clears any done flag left over from an earlier burst.
2. Software writes a small count, such as 4.
3. Software polls the status register until the done flag is set.
4. Software clears the done flag.

Top module: `cfgclk_burst`

## Requirements
- R1: After a synchronous reset, `cfg_clk_o`, `busy_o`, `done_o` and `bus_rdata` are all 0.
- R2: Consider a write of N > 0 (bits CNT_W-1:0 of `bus_wdata`) to offset 0x8 at clock edge E0. Then `cfg_clk_o` is high in exactly N cycles, after edges E1, E3, …, E(2N-1). Each of these cycles is followed by a low cycle.
- R3: After such a write, `busy_o` is high from edge E0 up to edge E(2N). At E(2N), `cfg_clk_o` returns low, `busy_o` falls and `done_o` rises. `cfg_clk_o` is never high while `busy_o` is low.
- R4: A count write of 0 sets `done_o` at the same edge, leaves `busy_o` low and sends no pulse.
- R5: A write to offset 0x8 is the only action that starts a burst. Status bit 0 (`done_o`) is write-one-to-clear: a write to offset 0xC with bit 0 set clears it. A write to offset 0xC with bit 0 clear has no effect.
- R6: If the final pulse ends at the same edge as a write-one-to-clear, `done_o` is set after that edge.
- R7: A count write while a burst is running abandons the running burst. `cfg_clk_o` is low after that edge, and exactly the new number of pulses follows, with the R2 timing.
- R8: A nonzero count write clears a stale `done_o` at the same edge.
- R9: In the cycle after `bus_rd`, `bus_rdata` returns one of three values. At offset 0xC it is {busy in bit 1, done in bit 0}. At offset 0x8 it is the number of pulses not yet completed. At any other offset it is 0. Without a read, `bus_rdata` is 0.
- R10: A write to any offset other than 0x8 or 0xC changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cfg_clk_o | output | 1 | Configuration clock pulse output |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | Sticky burst-complete flag |

## Verification
The assertions assume that `bus_wr` and `bus_rd` each carry one access per cycle, and that every input is driven to a known value once reset has been released. They also assume that a write-one-to-clear only has a guaranteed effect while the block is idle. For that reason, the clear property is qualified by `busy_o` being low.

The stimulus draws offsets from the two register offsets plus two unused ones. Count values are kept small so that bursts finish and restart often. Reads and writes are drawn independently each cycle. Directed sequences place a clear exactly on the completing edge and a restart in the middle of a burst.

// File: rtl/cfgclk_burst_pkg.sv
package cfgclk_burst_pkg;
  localparam int OFS_COUNT     = 8;
  localparam int OFS_STAT      = 12;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_BUSY_BIT = 1;
endpackage

// File: rtl/cbc_engine.sv
module cbc_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cfg_clk_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             finish_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last_fall;
  assign last_fall = busy_o && cfg_clk_o && (rem_o == ONE);
  // a load overrides any completion of the running burst
  assign finish_o  = load ? (load_val == '0) : last_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_clk_o <= 1'b0;
      busy_o    <= 1'b0;
      rem_o     <= '0;
    end else if (load) begin
      cfg_clk_o <= 1'b0;
      busy_o    <= (load_val != '0);
      rem_o     <= load_val;
    end else if (busy_o) begin
      if (cfg_clk_o) begin
        cfg_clk_o <= 1'b0;
        rem_o     <= rem_o - ONE;
        if (last_fall) busy_o <= 1'b0;
      end else begin
        cfg_clk_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbc_done.sv
module cbc_done (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o
);
  always_ff @(posedge clk) begin
    if (rst)        done_o <= 1'b0;
    else if (set_i) done_o <= 1'b1;   // set has priority over clear
    else if (clr_i) done_o <= 1'b0;
  end
endmodule

// File: rtl/cbc_rdmux.sv
module cbc_rdmux #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              done,
  input  logic              busy,
  input  logic [CNT_W-1:0]  rem,
  output logic [DATA_W-1:0] rdata
);
  import cfgclk_burst_pkg::*;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (rd) begin
      if (addr == ADDR_W'(OFS_STAT)) begin
        nxt[STAT_DONE_BIT] = done;
        nxt[STAT_BUSY_BIT] = busy;
      end else if (addr == ADDR_W'(OFS_COUNT)) begin
        nxt = DATA_W'(rem);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/cfgclk_burst.sv
module cfgclk_burst #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_clk_o,
  output logic              busy_o,
  output logic              done_o
);
  import cfgclk_burst_pkg::*;

  logic             wr_count, wr_stat, w1c;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] rem;
  logic             finish;

  assign wr_count = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign load_val = bus_wdata[CNT_W-1:0];
  assign w1c      = (wr_stat && bus_wdata[STAT_DONE_BIT]) ||
                    (wr_count && (load_val != '0));

  cbc_engine #(.CNT_W(CNT_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_count),
    .load_val (load_val),
    .cfg_clk_o(cfg_clk_o),
    .busy_o   (busy_o),
    .rem_o    (rem),
    .finish_o (finish)
  );

  cbc_done u_done (
    .clk   (clk),
    .rst   (rst),
    .set_i (finish),
    .clr_i (w1c),
    .done_o(done_o)
  );

  cbc_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .rd   (bus_rd),
    .addr (bus_addr),
    .done (done_o),
    .busy (busy_o),
    .rem  (rem),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/cfgclk_burst_chk.sv
module cfgclk_burst_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cfg_clk_o,
  input logic              busy_o,
  input logic              done_o
);
  import cfgclk_burst_pkg::*;

  logic cnt_wr, stat_w1c;
  assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign stat_w1c = bus_wr && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[STAT_DONE_BIT];

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!cfg_clk_o && !busy_o && !done_o && bus_rdata == '0));

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_clk_o |=> !cfg_clk_o);

  p_clk_in_burst_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_clk_o |-> busy_o);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_zero_count_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && bus_wdata[CNT_W-1:0] == '0) |=> (done_o && !busy_o && !cfg_clk_o));

  p_w1c_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_w1c && !busy_o && !cnt_wr) |=> !done_o);

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && bus_wdata[CNT_W-1:0] != '0) |=> (busy_o && !cfg_clk_o && !done_o));

  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind cfgclk_burst cfgclk_burst_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_clk_o(cfg_clk_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_cfgclk_burst.sv
`timescale 1ns/1ps
module test_cfgclk_burst;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          cfg_clk_o, busy_o, done_o;

  int n_chk = 0, n_bad = 0;

  // model state
  logic          m_clk = 0, m_busy = 0, m_done = 0;
  logic [CW-1:0] m_rem = '0;
  logic [DW-1:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  cfgclk_burst #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_cfgclk_burst (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_clk_o(cfg_clk_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // next state from the requirements
  task automatic model_edge(logic wr, logic rd, logic [AW-1:0] a, logic [DW-1:0] d);
    logic wc, ws, fin, nclk, nbusy;
    logic [CW-1:0] v, nrem;
    logic [DW-1:0] nrd;
    wc = wr && a == AW'(8);
    ws = wr && a == AW'(12) && d[0];
    v = d[CW-1:0];
    fin = 0; nclk = m_clk; nbusy = m_busy; nrem = m_rem;
    if (wc) begin
      nrem = v; nclk = 0; nbusy = (v != 0); fin = (v == 0);
    end else if (m_busy) begin
      if (m_clk) begin
        nclk = 0; nrem = m_rem - 1; fin = (m_rem == 1); nbusy = !fin;
      end else nclk = 1;
    end
    nrd = '0;
    if (rd && a == AW'(12)) nrd = {30'd0, m_busy, m_done};
    else if (rd && a == AW'(8)) nrd = DW'(m_rem);
    if (fin) m_done = 1;
    else if (ws || (wc && v != 0)) m_done = 0;
    m_clk = nclk; m_busy = nbusy; m_rem = nrem; m_rdata = nrd;
  endtask

  task automatic step(logic wr, logic rd, logic [AW-1:0] a, logic [DW-1:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(wr, rd, a, d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk("R2", "cfg_clk", DW'(cfg_clk_o), DW'(m_clk));
    chk("R3", "busy", DW'(busy_o), DW'(m_busy));
    chk("R5", "done", DW'(done_o), DW'(m_done));
    chk("R9", "rdata", bus_rdata, m_rdata);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int pulses;
    logic prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1", "cfg_clk", DW'(cfg_clk_o), 0);
    chk("R1", "busy", DW'(busy_o), 0);
    chk("R1", "done", DW'(done_o), 0);
    chk("R1", "rdata", bus_rdata, 0);

    // R2/R3: count 4, pulse count and done timing
    step(1, 0, 12'h8, 32'hABCD_0004);
    pulses = 0; prev = 0;
    for (int i = 1; i <= 8; i++) begin
      step(0, 0, '0, '0);
      if (cfg_clk_o && !prev) pulses++;
      prev = cfg_clk_o;
      if (i < 8) chk("R3", "done early", DW'(done_o), 0);
    end
    chk("R2", "pulse count", DW'(pulses), 4);
    chk("R3", "done at E8", DW'(done_o), 1);
    chk("R3", "busy at E8", DW'(busy_o), 0);

    // R5: write zero to status bit is ignored, then clear
    step(1, 0, 12'hC, 32'hFFFF_FFFE);
    chk("R5", "w0 no effect", DW'(done_o), 1);
    step(1, 0, 12'hC, 32'h1);
    chk("R5", "w1c", DW'(done_o), 0);

    // R4: zero count
    step(1, 0, 12'h8, 32'h0);
    chk("R4", "zero done", DW'(done_o), 1);
    chk("R4", "zero busy", DW'(busy_o), 0);
    step(0, 1, 12'h8, '0);
    chk("R4", "no pulse", DW'(cfg_clk_o), 0);

    // R10: unused offsets
    step(1, 0, 12'h0, 32'h5);
    step(1, 0, 12'h4, 32'h1);
    chk("R10", "done kept", DW'(done_o), 1);
    chk("R10", "busy kept", DW'(busy_o), 0);

    // R8: nonzero count clears stale done
    step(1, 0, 12'h8, 32'h1);
    chk("R8", "stale cleared", DW'(done_o), 0);
    // R6: clear lands on finishing edge E2
    step(0, 0, '0, '0);
    step(1, 0, 12'hC, 32'h1);
    chk("R6", "set wins", DW'(done_o), 1);

    // R7: restart mid-burst
    step(1, 0, 12'h8, 32'h5);
    idle(3);
    step(1, 0, 12'h8, 32'h2);
    chk("R7", "low after restart", DW'(cfg_clk_o), 0);
    pulses = 0; prev = 0;
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 12'h8, '0);
      if (cfg_clk_o && !prev) pulses++;
      prev = cfg_clk_o;
    end
    chk("R7", "new pulse count", DW'(pulses), 2);
    chk("R7", "done after restart", DW'(done_o), 1);

    // R9: read status with done set
    step(0, 1, 12'hC, '0);
    chk("R9", "status read", bus_rdata, 32'h1);

    // random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 12'h8 : (sel == 1) ? 12'hC : (sel == 2) ? 12'h0 : 12'h4;
      d = $urandom();
      if (a == 12'h8) d = {d[31:16], 12'd0, 4'($urandom_range(0, 6))};
      step(($urandom_range(0, 9) == 0), ($urandom_range(0, 2) == 0), a, d);
    end
    summary();
  end
endmodule